// File: doc/BRIEF.md
# Serial Shift-Register GPIO Expander Controller

This block adds up to 64 output pins and 64 input pins to a chip through four wires. The outputs go through a chain of latching serial-in/parallel-out shift registers, and the inputs come back through a chain of parallel-in/serial-out shift registers. One scan moves data in both directions on a single shift clock. The controller shifts the output bits out on the data-out wire and samples the input bits from the data-in wire. It then pulses a shared strobe low and back high. While the strobe is low, the input chain parallel-loads its pins. The rising edge of the strobe copies the shifted output bits onto the output chain's pins.

The shift clock is derived from the bus clock. Each half-period lasts a programmable number of bus cycles. Software-facing inputs set three values: the divider, the number of output bytes and the number of input bytes. They also supply the output word, provide a one-cycle start pulse and a continuous-refresh level, and read back the busy flag and the captured input word. Configuration and output data are latched when a scan starts, so a value written during a scan takes effect in the next one.

Top module: `serexp_ctrl`

## Requirements
- R1: After reset and whenever no scan runs, strobe is 1, shift clock is 0, busy is 0, and the captured input word is 0 until the first scan ends.
- R2: A start pulse while idle begins a scan. Busy stays high from the cycle after start until the cycle in which the strobe rises, and for one scan this is exactly 2·N·D + D cycles (N scan bits, D effective divider). A start pulse during a scan is ignored.
- R3: A scan produces N = 8·max(out_bytes, in_bytes) rising shift-clock edges. A byte count of 0 counts as 1, and a count above the maximum counts as the maximum.
- R4: Each shift-clock low and high half-period lasts D = cfg_div bus cycles, and a divider of 0 counts as 1. Over a scan the shift clock is high for N·D cycles.
- R5: Data out changes only while the shift clock is low, and it holds its value for as long as the shift clock is high.
- R6: Output bits are sent from bit 8·out_bytes−1 down to bit 0, preceded by N − 8·out_bytes zero bits. After the strobe rises, output chain pin k (k = 0 is the first stage fed from data out) equals out_data[k] for every k below 8·out_bytes.
- R7: Data in is sampled in the bus cycle just before each rising shift-clock edge, starting with the first one. After the scan, the first bit that arrived sits at in_data[N−1] and the last at in_data[0], and the bits from N upward are 0.
- R8: After the last bit, the shift clock stays low and the strobe is low for exactly D cycles. The strobe's rising edge ends the scan.
- R9: in_data changes only at the end of a scan and holds its previous value throughout a scan. A new out_data written during a scan appears on the output pins only after the next scan.
- R10: While continuous is high, a new scan starts on the cycle after the previous one ends, so busy is low for exactly one cycle between scans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Half-period of the shift clock in bus cycles (0 treated as 1) |
| cfg_out_bytes | input | clog2(MAX_BYTES+1) | Number of output-chain devices |
| cfg_in_bytes | input | clog2(MAX_BYTES+1) | Number of input-chain devices |
| out_data | input | 8·MAX_BYTES | Output pin values, bit k to pin k |
| start | input | 1 | One-cycle request for a single scan |
| continuous | input | 1 | Level request for back-to-back scans |
| busy | output | 1 | High while a scan is in progress |
| in_data | output | 8·MAX_BYTES | Input bits captured by the last completed scan |
| sdo | output | 1 | Serial data to the first output device |
| sclk | output | 1 | Shift clock for both chains |
| strobe | output | 1 | Output latch clock and input load select (low loads) |
| sdi | input | 1 | Serial data from the last input device |

## Verification
The hardest case to reach from the ports is a pair of chains of unequal length. Here the zero padding and the alignment of the input word depend on which chain is longer. The bench contains behavioural models of both external chains, driven only from the four wires. For each configuration it first runs a priming scan that parallel-loads known input pins, then a measured scan. The measured scan's captured word and latched outputs are compared with values computed from the byte counts. Mid-scan writes and start pulses are injected a fixed number of cycles into a running scan, which shows that they are deferred or ignored.

// File: rtl/serexp_pkg.sv
`timescale 1ns/1ps
package serexp_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_LOAD} scan_state_e;

  // Divider of zero behaves as one bus cycle per half-period.
  function automatic int eff_div(int d);
    return (d == 0) ? 1 : d;
  endfunction

  // Chain length clamped to the supported range.
  function automatic int eff_bytes(int b, int maxb);
    if (b < 1) return 1;
    if (b > maxb) return maxb;
    return b;
  endfunction

  // Bits moved in one scan: the longer chain decides.
  function automatic int scan_len(int ob, int ib, int maxb);
    int o;
    int i;
    o = eff_bytes(ob, maxb);
    i = eff_bytes(ib, maxb);
    return 8 * ((o > i) ? o : i);
  endfunction

endpackage

// File: rtl/serexp_div.sv
`timescale 1ns/1ps
module serexp_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == (half - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/serexp_seq.sv
`timescale 1ns/1ps
module serexp_seq
  import serexp_pkg::*;
#(
  parameter int BIT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             tick,
  input  logic [BIT_W-1:0] scan_bits,
  output scan_state_e      state,
  output logic             sclk,
  output logic             strobe,
  output logic             accept,
  output logic             sample_en,
  output logic             shift_en,
  output logic             done
);
  logic [BIT_W-1:0] left;
  logic             last;

  assign last      = (left == BIT_W'(1));
  assign accept    = (state == ST_IDLE) && start_req;
  assign sample_en = (state == ST_LOW) && tick;
  assign shift_en  = (state == ST_HIGH) && tick && !last;
  assign done      = (state == ST_LOAD) && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sclk   <= 1'b0;
      strobe <= 1'b1;
      left   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_req) begin
          state <= ST_LOW;
          left  <= scan_bits;
        end
        ST_LOW: if (tick) begin
          state <= ST_HIGH;
          sclk  <= 1'b1;
        end
        ST_HIGH: if (tick) begin
          sclk <= 1'b0;
          if (last) begin
            state  <= ST_LOAD;
            strobe <= 1'b0;
          end else begin
            state <= ST_LOW;
            left  <= left - 1'b1;
          end
        end
        ST_LOAD: if (tick) begin
          state  <= ST_IDLE;
          strobe <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serexp_data.sv
`timescale 1ns/1ps
module serexp_data #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] out_word,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              sdi,
  input  logic              done,
  output logic              sdo,
  output logic [DATA_W-1:0] in_data
);
  logic [DATA_W-1:0] out_sr;
  logic [DATA_W-1:0] in_sr;

  assign sdo = out_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sr  <= '0;
      in_sr   <= '0;
      in_data <= '0;
    end else begin
      if (accept)        out_sr <= out_word;
      else if (shift_en) out_sr <= {out_sr[DATA_W-2:0], 1'b0};
      if (accept)         in_sr <= '0;
      else if (sample_en) in_sr <= {in_sr[DATA_W-2:0], sdi};
      if (done) in_data <= in_sr;
    end
  end
endmodule

// File: rtl/serexp_ctrl.sv
`timescale 1ns/1ps
module serexp_ctrl
  import serexp_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int DIV_W     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [DIV_W-1:0]               cfg_div,
  input  logic [$clog2(MAX_BYTES+1)-1:0] cfg_out_bytes,
  input  logic [$clog2(MAX_BYTES+1)-1:0] cfg_in_bytes,
  input  logic [8*MAX_BYTES-1:0]         out_data,
  input  logic                           start,
  input  logic                           continuous,
  output logic                           busy,
  output logic [8*MAX_BYTES-1:0]         in_data,
  output logic                           sdo,
  output logic                           sclk,
  output logic                           strobe,
  input  logic                           sdi
);
  localparam int DATA_W = 8 * MAX_BYTES;
  localparam int BIT_W  = $clog2(DATA_W + 1);

  // Mask the live bytes and left-justify them in an N-bit window.
  function automatic logic [DATA_W-1:0] align_out(logic [DATA_W-1:0] d, int nout, int nscan);
    logic [DATA_W:0] m;
    m = (DATA_W+1)'(1) << nout;
    m = m - 1'b1;
    return (d & m[DATA_W-1:0]) << (DATA_W - nscan);
  endfunction

  scan_state_e       state;
  logic              tick, accept, sample_en, shift_en, done;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  scan_bits;
  logic [DATA_W-1:0] out_word;

  always_comb begin
    scan_bits = BIT_W'(scan_len(int'(cfg_out_bytes), int'(cfg_in_bytes), MAX_BYTES));
    out_word  = align_out(out_data, 8 * eff_bytes(int'(cfg_out_bytes), MAX_BYTES), int'(scan_bits));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= DIV_W'(1);
    else if (accept) div_q <= DIV_W'(eff_div(int'(cfg_div)));
  end

  assign busy = (state != ST_IDLE);

  serexp_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(div_q), .tick(tick)
  );

  serexp_seq #(.BIT_W(BIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start || continuous), .tick(tick),
    .scan_bits(scan_bits), .state(state), .sclk(sclk), .strobe(strobe),
    .accept(accept), .sample_en(sample_en), .shift_en(shift_en), .done(done)
  );

  serexp_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .accept(accept), .out_word(out_word),
    .shift_en(shift_en), .sample_en(sample_en), .sdi(sdi), .done(done),
    .sdo(sdo), .in_data(in_data)
  );
endmodule

// File: rtl/serexp_checks.sv
`timescale 1ns/1ps
module serexp_checks #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          sclk,
  input logic          strobe,
  input logic          sdo,
  input logic          sample_en,
  input logic [DW-1:0] in_data
);
  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (strobe && !sclk));

  assert_scan_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $fell(busy));

  assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdo));

  assert_sample_before_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> $rose(sclk));

  assert_load_clock_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (!sclk && busy));

  assert_input_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(in_data));
endmodule

bind serexp_ctrl serexp_checks #(.DW(8 * MAX_BYTES)) u_checks (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .strobe(strobe),
  .sdo(sdo), .sample_en(sample_en), .in_data(in_data)
);

// File: tb/serexp_ctrl_test.sv
`timescale 1ns/1ps
module serexp_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic [3:0]  cfg_out_bytes = 4'd8;
  logic [3:0]  cfg_in_bytes = 4'd8;
  logic [63:0] out_data = '0;
  logic        start = 1'b0;
  logic        continuous = 1'b0;
  logic        busy, sdo, sclk, strobe, sdi;
  logic [63:0] in_data;

  always #2.5 clk = ~clk;

  serexp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_out_bytes(cfg_out_bytes),
    .cfg_in_bytes(cfg_in_bytes), .out_data(out_data), .start(start),
    .continuous(continuous), .busy(busy), .in_data(in_data), .sdo(sdo),
    .sclk(sclk), .strobe(strobe), .sdi(sdi)
  );

  int errors = 0;
  int checks = 0;

  // External chain models and edge counters, all updated away from the active edge.
  logic [63:0] sr595 = '0, lat595 = '0, sr165 = '0, pins_in = '0;
  int in_len = 8;
  logic sclk_p = 1'b0, strobe_p = 1'b1;
  int n_busy = 0, n_hi = 0, n_rise = 0, n_lo = 0;
  int s_busy, s_hi, s_rise, s_lo;
  int d_busy, d_hi, d_rise, d_lo;

  assign sdi = sr165[in_len-1];

  always @(negedge clk) begin
    if (sclk && !sclk_p) begin
      sr595 <= {sr595[62:0], sdo};
      if (strobe) sr165 <= {sr165[62:0], 1'b0};
      n_rise <= n_rise + 1;
    end
    if (strobe && !strobe_p) lat595 <= sr595;
    if (!strobe) sr165 <= pins_in;
    if (busy) n_busy <= n_busy + 1;
    if (sclk) n_hi <= n_hi + 1;
    if (!strobe) n_lo <= n_lo + 1;
    sclk_p   <= sclk;
    strobe_p <= strobe;
  end

  function automatic int effb(int b);
    return (b < 1) ? 1 : ((b > 8) ? 8 : b);
  endfunction

  function automatic logic [63:0] mk(int bits);
    return (bits >= 64) ? '1 : ((64'd1 << bits) - 64'd1);
  endfunction

  task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chki(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    s_busy = n_busy; s_hi = n_hi; s_rise = n_rise; s_lo = n_lo;
  endtask

  task automatic delta();
    d_busy = n_busy - s_busy; d_hi = n_hi - s_hi;
    d_rise = n_rise - s_rise; d_lo = n_lo - s_lo;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic scan_once();
    snap();
    pulse_start();
    wait_idle();
    delta();
  endtask

  task automatic t_reset();
    chki("R1 busy after reset", int'(busy), 0);
    chki("R1 strobe after reset", int'(strobe), 1);
    chki("R1 sclk after reset", int'(sclk), 0);
    chk64("R1 in_data after reset", in_data, 64'd0);
  endtask

  // Priming scan loads the input pins; measured scan checks both directions.
  task automatic run_case(string tag, int ob, int ib, int dv, logic [63:0] pins, logic [63:0] outv);
    int n, d;
    n = 8 * ((effb(ob) > effb(ib)) ? effb(ob) : effb(ib));
    d = (dv == 0) ? 1 : dv;
    cfg_out_bytes = 4'(ob); cfg_in_bytes = 4'(ib); cfg_div = 8'(dv);
    in_len = 8 * effb(ib);
    pins_in = pins;
    out_data = outv;
    scan_once();
    out_data = ~outv;
    scan_once();
    chki({tag, " R2 busy cycles"}, d_busy, 2 * n * d + d);
    chki({tag, " R3 rising edges"}, d_rise, n);
    chki({tag, " R4 high cycles"}, d_hi, n * d);
    chki({tag, " R8 strobe low cycles"}, d_lo, d);
    chk64({tag, " R6 output pins"}, lat595 & mk(8 * effb(ob)), ~outv & mk(8 * effb(ob)));
    chk64({tag, " R7 input word"}, in_data, (pins & mk(8 * effb(ib))) << (n - 8 * effb(ib)));
    chki({tag, " R1 idle strobe"}, int'(strobe), 1);
  endtask

  task automatic t_midwrite();
    logic [63:0] prev;
    cfg_out_bytes = 4'd4; cfg_in_bytes = 4'd4; cfg_div = 8'd2;
    in_len = 32;
    pins_in = 64'h0000_0000_C0DE_F00D;
    out_data = 64'h0000_0000_1234_5678;
    scan_once();
    prev = in_data;
    pins_in = 64'h0000_0000_0BAD_CAFE;
    pulse_start();
    repeat (30) @(negedge clk);
    out_data = 64'h0000_0000_8765_4321;
    @(negedge clk);
    chki("R9 busy mid scan", int'(busy), 1);
    chk64("R9 in_data held mid scan", in_data, prev);
    wait_idle();
    chk64("R9 old output used", lat595 & mk(32), 64'h1234_5678);
    chk64("R9 input updated at end", in_data, 64'hC0DE_F00D);
    scan_once();
    chk64("R9 new output next scan", lat595 & mk(32), 64'h8765_4321);
  endtask

  task automatic t_ignore_start();
    cfg_out_bytes = 4'd1; cfg_in_bytes = 4'd2; cfg_div = 8'd2;
    in_len = 16;
    snap();
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    wait_idle();
    repeat (6) @(negedge clk);
    delta();
    chki("R2 start during scan ignored: busy cycles", d_busy, 2 * 16 * 2 + 2);
    chki("R2 start during scan ignored: edges", d_rise, 16);
    chki("R2 idle after scan", int'(busy), 0);
  endtask

  task automatic t_continuous();
    int gap;
    cfg_out_bytes = 4'd1; cfg_in_bytes = 4'd1; cfg_div = 8'd1;
    in_len = 8;
    @(negedge clk) continuous = 1'b1;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    gap = 0;
    while (!busy) begin
      gap++;
      @(negedge clk);
    end
    chki("R10 idle gap between scans", gap, 1);
    continuous = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    chki("R10 stops when cleared", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case("full", 8, 8, 1, 64'hA5C3_1E0F_7B29_D486, 64'h0123_4567_89AB_CDEF);
    run_case("in-longer", 2, 5, 3, 64'h0000_00F1_E2D3_C4B5, 64'h0000_0000_0000_9A3C);
    run_case("out-longer", 6, 1, 2, 64'h0000_0000_0000_0096, 64'h0000_5A5A_F00F_1248);
    run_case("clamped", 0, 12, 0, 64'hDEAD_BEEF_0F1E_2D3C, 64'h0000_0000_0000_00C7);
    t_midwrite();
    t_ignore_start();
    t_continuous();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule